// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a bus-attached watchdog. Software programs a timeout, in clock ticks, into a preset register. While the watchdog is armed, a live counter counts down by one per clock. Software must service it, either by rewriting the preset or by writing the service location, before the counter runs out. If the counter reaches zero while armed, the block emits a single-cycle reset-event pulse and sets a sticky expired flag. Software reads that flag back and clears it by writing a one.

The watchdog is switched off by only one 16-bit code, 0x0AD0, written to the control register. Every other control value leaves it armed, including zero, so a stray or corrupted write cannot silence it. The block comes out of reset switched off, with its preset and counter at zero. Software loads a timeout and then writes any other control value to start the countdown.

The register port is a simple write strobe with a 2-bit word address and a registered read. The address decodes as follows: 0 is the preset, 1 is control, 2 is the live counter (writing it services the watchdog), and 3 is the flag word (bit 0 is expired).

Top module: `wdog_keyed`

## Requirements
- R1: After reset the control register reads 0x0AD0, the preset and live counter read 0, the expired flag reads 0, and `rst_event` is low.
- R2: While the control register holds 0x0AD0 the live counter keeps its value and no reset event occurs.
- R3: Any control value other than 0x0AD0 arms the watchdog. A control write that changes the state from switched off to armed reloads the live counter from the preset.
- R4: A write to address 0 stores the preset and loads the live counter with the written value, whether or not the watchdog is armed.
- R5: A write of any data to address 2 reloads the live counter from the stored preset.
- R6: While armed with a nonzero live counter and no reload, the counter decreases by exactly one per clock.
- R7: When the counter is loaded with N while armed, `rst_event` goes high for exactly one cycle, N+1 clocks after the loading edge. A single load produces at most one pulse.
- R8: After expiry the live counter stays at zero, and no further pulse occurs, until a reload.
- R9: The expired flag is set together with the pulse and reads as bit 0 at address 3. It stays set until a write to address 3 with bit 0 = 1. A write there with bit 0 = 0 leaves it unchanged.
- R10: `rdata` shows the register selected by `addr` one clock after the address is applied.
- R11: A reload write in the same cycle as a decrement takes precedence, so the counter holds the reload value afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for `addr` |
| rst_event | output | 1 | Single-cycle pulse on expiry |
| expired | output | 1 | Sticky expiry flag |

## Verification
The hardest cases to reach from the ports are two timing collisions. The first is a service write arriving in the same cycle that the counter would otherwise decrement. The second is the exact edge on which the counter, already at zero, fires exactly once. The bench services a running counter mid-count, then sweeps the preset from 0 to 15 and counts clocks to each pulse against N+1. It also sweeps the control field through every single-bit neighbour of the switch-off code, plus a few other values, to confirm that only the exact code silences the counter.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_PRESET = 2'd0,
    RA_CTRL   = 2'd1,
    RA_LIVE   = 2'd2,
    RA_FLAGS  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wdk_regfile.sv
module wdk_regfile
  import wdk_pkg::*;
#(
  parameter int          CNT_W   = 32,
  parameter int          CTL_W   = 16,
  parameter logic [15:0] OFF_KEY = 16'h0AD0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              fire_now,
  output logic [CNT_W-1:0]  preset_q,
  output logic [CTL_W-1:0]  ctrl_q,
  output logic              armed,
  output logic              reload,
  output logic [CNT_W-1:0]  reload_val,
  output logic              expired_q
);
  localparam logic [CTL_W-1:0] KEY = CTL_W'(OFF_KEY);

  logic             wr_pre, wr_ctl, wr_live, wr_flg, wake;
  logic [CTL_W-1:0] ctl_next;

  always_comb begin
    wr_pre   = wr_en && (addr == RA_PRESET);
    wr_ctl   = wr_en && (addr == RA_CTRL);
    wr_live  = wr_en && (addr == RA_LIVE);
    wr_flg   = wr_en && (addr == RA_FLAGS);
    ctl_next = wdata[CTL_W-1:0];
    armed    = (ctrl_q != KEY);
    wake     = wr_ctl && !armed && (ctl_next != KEY);
    reload   = wr_pre || wr_live || wake;
    reload_val = wr_pre ? wdata : preset_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preset_q  <= '0;
      ctrl_q    <= KEY;
      expired_q <= 1'b0;
    end else begin
      if (wr_pre) preset_q <= wdata;
      if (wr_ctl) ctrl_q <= ctl_next;
      if (fire_now) expired_q <= 1'b1;
      else if (wr_flg && wdata[0]) expired_q <= 1'b0;
    end
  end

  // R3: a non-key control write leaves the watchdog armed
  a_r3_nonkey_arms: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && ctl_next != KEY) |=> armed);
  // R2: the key control write switches the watchdog off
  a_r2_key_disarms: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && ctl_next == KEY) |=> !armed);
  // R9: the flag stays set unless cleared by a one in bit 0
  a_r9_expired_sticky: assert property (@(posedge clk) disable iff (rst)
    (expired_q && !(wr_flg && wdata[0])) |=> expired_q);
  // R9: a write of zero to the flag word never clears the flag
  a_r9_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_flg && !wdata[0] && expired_q) |=> expired_q);
endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] live_q,
  output logic             fire_now,
  output logic             pulse_q
);
  logic spent_q;

  always_comb begin
    fire_now = armed && !reload && (live_q == '0) && !spent_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      spent_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fire_now;
      if (reload) begin
        live_q  <= reload_val;
        spent_q <= 1'b0;
      end else if (armed) begin
        if (live_q != '0) live_q <= live_q - 1'b1;
        if (fire_now) spent_q <= 1'b1;
      end
    end
  end

  // R6: one step down per clock while armed and running
  a_r6_step_down: assert property (@(posedge clk) disable iff (rst)
    (armed && !reload && live_q != '0) |=> (live_q == $past(live_q) - 1'b1));
  // R2: switched off and no reload means the counter holds
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!armed && !reload) |=> $stable(live_q));
  // R4 / R5 / R11: a reload wins over any decrement
  a_r11_reload_wins: assert property (@(posedge clk) disable iff (rst)
    reload |=> (live_q == $past(reload_val)));
  // R8: once expired the counter stays parked at zero
  a_r8_parked_zero: assert property (@(posedge clk) disable iff (rst)
    (armed && !reload && live_q == '0) |=> (live_q == '0));
  // R7: the reset event lasts one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
endmodule

// File: rtl/wdk_readport.sv
module wdk_readport
  import wdk_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int CTL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  preset_q,
  input  logic [CTL_W-1:0]  ctrl_q,
  input  logic [CNT_W-1:0]  live_q,
  input  logic              expired_q,
  output logic [CNT_W-1:0]  rdata
);
  logic [CNT_W-1:0] sel;

  always_comb begin
    case (addr)
      RA_PRESET: sel = preset_q;
      RA_CTRL:   sel = CNT_W'(ctrl_q);
      RA_LIVE:   sel = live_q;
      default:   sel = CNT_W'(expired_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdk_pkg::*;
#(
  parameter int          CNT_W   = 32,
  parameter int          CTL_W   = 16,
  parameter logic [15:0] OFF_KEY = 16'h0AD0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              rst_event,
  output logic              expired
);
  logic [CNT_W-1:0] preset_q, live_q, reload_val;
  logic [CTL_W-1:0] ctrl_q;
  logic             armed, reload, fire_now, expired_q, pulse_q;

  wdk_regfile #(.CNT_W(CNT_W), .CTL_W(CTL_W), .OFF_KEY(OFF_KEY)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .fire_now(fire_now), .preset_q(preset_q), .ctrl_q(ctrl_q),
    .armed(armed), .reload(reload), .reload_val(reload_val),
    .expired_q(expired_q)
  );

  wdk_countdown #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .armed(armed), .reload(reload),
    .reload_val(reload_val), .live_q(live_q), .fire_now(fire_now),
    .pulse_q(pulse_q)
  );

  wdk_readport #(.CNT_W(CNT_W), .CTL_W(CTL_W)) rd_i (
    .clk(clk), .rst(rst), .addr(addr), .preset_q(preset_q),
    .ctrl_q(ctrl_q), .live_q(live_q), .expired_q(expired_q), .rdata(rdata)
  );

  assign rst_event = pulse_q;
  assign expired   = expired_q;

  // R7 / R9: every reset event is accompanied by the sticky flag
  a_r7_pulse_flags: assert property (@(posedge clk) disable iff (rst)
    rst_event |-> expired);
  // R8: a reset event leaves the counter at zero
  a_r8_zero_at_pulse: assert property (@(posedge clk) disable iff (rst)
    (rst_event && !reload) |-> (live_q == '0));
endmodule

// File: tb/wdog_keyed_tb_top.sv
module wdog_keyed_tb_top;
  localparam logic [15:0] KEY = 16'h0AD0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_event, expired;
  int n_chk = 0, n_fail = 0, pulses = 0;

  always #2 clk = ~clk;

  wdog_keyed dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rst_event(rst_event), .expired(expired)
  );

  always @(posedge clk) if (!rst && rst_event) pulses++;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic clocks_to_pulse(output int c);
    c = 0;
    while (!rst_event && c < 200) begin
      @(negedge clk);
      c++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, a;
    int c, p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(2'd1, v); check("R1 ctrl", v, 32'h0AD0);
    rd(2'd0, v); check("R1 preset", v, 0);
    rd(2'd2, v); check("R1 live", v, 0);
    rd(2'd3, v); check("R1 flag", v, 0);
    check("R1 rst_event", {31'b0, rst_event}, 0);

    // R4: preset write while off loads preset and counter
    wr(2'd0, 32'd100);
    rd(2'd0, v); check("R4 preset", v, 100);
    // R10: rdata changes only after the next edge
    addr = 2'd1; #1;
    check("R10 old value held", rdata, 100);
    @(negedge clk); check("R10 new value", rdata, 32'h0AD0);
    rd(2'd2, v); check("R4 live", v, 100);
    // R2: held while off
    repeat (5) @(negedge clk);
    rd(2'd2, v); check("R2 hold off", v, 100);

    // R3 / R6: enabling with zero reloads, then counts down
    wr(2'd1, 32'd0);
    rd(2'd2, v); check("R3 reload on enable", v, 100);
    rd(2'd2, v); check("R6 step", v, 99);
    repeat (10) @(negedge clk);
    check("R6 ten steps", rdata, 89);

    // R2: key disables mid-count
    wr(2'd1, {16'h0, KEY});
    rd(2'd2, a);
    repeat (5) @(negedge clk);
    rd(2'd2, v); check("R2 frozen", v, a);

    // R5 / R11: service while running reloads from preset
    wr(2'd1, 32'd0);
    repeat (7) @(negedge clk);
    wr(2'd2, 32'hDEAD_BEEF);
    rd(2'd2, v); check("R11 service wins over step", v, 100);
    rd(2'd0, v); check("R5 preset unchanged", v, 100);

    // R7 / R9: sweep of presets, N+1 clocks to a single pulse
    for (int n = 0; n < 16; n++) begin
      wr(2'd3, 32'd1);
      p0 = pulses;
      wr(2'd0, n);
      clocks_to_pulse(c);
      check("R7 clocks to pulse", c, n + 1);
      @(negedge clk);
      check("R7 pulse one cycle", {31'b0, rst_event}, 0);
      check("R7 one pulse", pulses - p0, 1);
      rd(2'd3, v); check("R9 flag set", v, 1);
    end

    // R8: parked at zero, no further pulse
    p0 = pulses;
    repeat (20) @(negedge clk);
    rd(2'd2, v); check("R8 parked", v, 0);
    check("R8 no repeat pulse", pulses - p0, 0);

    // R9: clearing rules
    wr(2'd3, 32'd2);
    rd(2'd3, v); check("R9 zero bit keeps flag", v, 1);
    wr(2'd3, 32'd1);
    rd(2'd3, v); check("R9 cleared", v, 0);

    // R3: every near-miss control value arms the watchdog
    for (int i = 0; i < 19; i++) begin
      logic [15:0] cv;
      cv = (i < 16) ? (KEY ^ (16'h1 << i)) :
           (i == 16) ? 16'h0000 : (i == 17) ? 16'hFFFF : 16'h5A5A;
      wr(2'd1, {16'h0, KEY});
      wr(2'd0, 32'd3);
      wr(2'd3, 32'd1);
      wr(2'd1, {16'h0, cv});
      clocks_to_pulse(c);
      check("R3 near-miss value arms", c, 4);
    end

    // R2: the key alone keeps it silent
    wr(2'd1, {16'h0, KEY});
    wr(2'd0, 32'd3);
    p0 = pulses;
    repeat (30) @(negedge clk);
    check("R2 no pulse while off", pulses - p0, 0);
    rd(2'd2, v); check("R2 live held", v, 3);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule